// File: doc/BRIEF.md
# BCD Calendar Clock with Full-Match Alarm

This block is a calendar clock core that counts from a slow tick enable, nominally 32.768 kHz, sampled in the system clock domain. It holds the time of day and the date as six packed-BCD byte fields: seconds, minutes, hours (24-hour only), day of month, month and a two-digit year that stands for 2000 to 2099. Day rollover follows the length of each month, with a 29th of February in every year divisible by four.

A byte-wide register port reads and writes the time fields, a second set of six alarm fields, a run control, a status register and an interrupt-enable register. The alarm has no masked fields. It fires only when every one of the six time fields equals its alarm field. Each second also raises periodic event flags for the second, minute, hour and day. A busy flag is high during the last tick interval before each seconds update. Software polls it and starts a multi-byte access only after it falls, so the time cannot change underneath the access. Any write to a time field restarts the sub-second prescale.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the time reads 00:00:00 on day 0x01 of month 0x01 of year 0x00. All alarm fields read 0x00. Control, status and interrupt-enable read 0x00, and irq is low.
- R2: The time fields are at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 (seconds, minutes, hours, day, month, year). The alarm fields are at 0x20 to 0x34 in the same order. Control is at 0x40, status at 0x44 and interrupt-enable at 0x48. A written time or alarm byte reads back unchanged.
- R3: Control bit 0 set to 1 lets the clock count, and status bit 1 mirrors it. With control bit 0 at 0, tick enables do not change the time.
- R4: While running, the seconds field advances once for every TICKS_PER_SEC tick enables. A write to any time field restarts this count from zero.
- R5: Status bit 0 (busy) is 1 exactly while TICKS_PER_SEC-1 ticks of the current second have elapsed and the clock runs. It returns to 0 with the seconds update.
- R6: The fields count in packed BCD. A low digit of 9 carries into the high digit. Seconds and minutes wrap from 0x59 to 0x00 and carry onward, and hours wrap from 0x23 to 0x00.
- R7: The day wraps to 0x01 after the last day of the month: 0x31, 0x30, or for February 0x29 in leap years and 0x28 otherwise. Month 0x12 wraps to 0x01, and year 0x99 wraps to 0x00.
- R8: Status bit 6 (alarm) is set by the seconds update that makes all six time fields equal the six alarm fields. One differing field, the year included, keeps it clear.
- R9: Each seconds update sets status bit 2. Status bit 3 is set when seconds wrap, bit 4 when minutes also wrap, and bit 5 when hours also wrap. These flags stay set until cleared.
- R10: Writing status clears every flag in bits 6..2 whose written bit is 1 and leaves the others unchanged. A flag set in the same cycle stays set.
- R11: irq is high when status bit 6 and interrupt-enable bit 3 are both 1, or when status bit 2 and interrupt-enable bit 2 are both 1. Writing 0x00 to interrupt-enable forces irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse per 32 kHz period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte register offset for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| irq | output | 1 | Interrupt request, level |

## Verification
The bench drives the clock across the whole-calendar rollover (31 December 99, 23:59:59) and across the end of February in a leap year and in a common year. A design with a wrong month-length table, or one that treats every year as leap, shows a wrong day or month at these points. It also checks a BCD digit carry from 0x09 to 0x10; binary counting would show 0x0A. The alarm is checked once with all six fields equal and once with only the year different. A design that compares only the time of day would raise the flag in the second case. Busy is sampled one tick before and one tick after the update. The bench also tests that a time write restarts the prescale, that a zero write to status leaves the alarm flag set, and that the enable bits mask irq.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int NUM_FIELDS = 6;
  localparam int FLD_SEC  = 0;
  localparam int FLD_MIN  = 1;
  localparam int FLD_HOUR = 2;
  localparam int FLD_DAY  = 3;
  localparam int FLD_MON  = 4;
  localparam int FLD_YEAR = 5;

  localparam logic [7:0] OFS_CTRL = 8'h40;
  localparam logic [7:0] OFS_STAT = 8'h44;
  localparam logic [7:0] OFS_IEN  = 8'h48;

  localparam logic [2:0] BANK_TIME  = 3'b000;
  localparam logic [2:0] BANK_ALARM = 3'b001;

  // add one to a packed BCD byte (no wrap handling)
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic is_leap(input logic [7:0] year_bcd);
    logic [6:0] b;
    b = bcd_to_bin(year_bcd);
    return b[1:0] == 2'b00;
  endfunction

  // last day of a month, in BCD
  function automatic logic [7:0] last_day(input logic [7:0] mon_bcd,
                                          input logic [7:0] year_bcd);
    case (mon_bcd)
      8'h02:                      return is_leap(year_bcd) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick_en,
  input  logic restart,
  output logic busy,
  output logic step
);
  localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);

  logic [PW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign busy    = run & at_last;
  assign step    = run & tick_en & at_last & ~restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (restart)        cnt_q <= '0;
    else if (run && tick_en) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step,
  input  logic                    wr_en,
  input  logic [2:0]              wr_field,
  input  logic [7:0]              wdata,
  output logic [8*NUM_FIELDS-1:0] time_o,
  output logic [8*NUM_FIELDS-1:0] next_o,
  output logic                    evt_min,
  output logic                    evt_hour,
  output logic                    evt_day
);
  logic [7:0] sec, mins, hour, day, mon, year;
  logic       c_sec, c_min, c_hour, c_day, c_mon;

  assign sec  = time_o[8*FLD_SEC  +: 8];
  assign mins = time_o[8*FLD_MIN  +: 8];
  assign hour = time_o[8*FLD_HOUR +: 8];
  assign day  = time_o[8*FLD_DAY  +: 8];
  assign mon  = time_o[8*FLD_MON  +: 8];
  assign year = time_o[8*FLD_YEAR +: 8];

  // carry chain: each stage wraps only if all lower ones wrap
  assign c_sec  = (sec  >= 8'h59);
  assign c_min  = c_sec  & (mins >= 8'h59);
  assign c_hour = c_min  & (hour >= 8'h23);
  assign c_day  = c_hour & (day  >= last_day(mon, year));
  assign c_mon  = c_day  & (mon  >= 8'h12);

  always_comb begin
    next_o = time_o;
    next_o[8*FLD_SEC +: 8] = c_sec ? 8'h00 : bcd_inc(sec);
    if (c_sec)  next_o[8*FLD_MIN  +: 8] = (mins >= 8'h59) ? 8'h00 : bcd_inc(mins);
    if (c_min)  next_o[8*FLD_HOUR +: 8] = (hour >= 8'h23) ? 8'h00 : bcd_inc(hour);
    if (c_hour) next_o[8*FLD_DAY  +: 8] = c_day ? 8'h01 : bcd_inc(day);
    if (c_day)  next_o[8*FLD_MON  +: 8] = c_mon ? 8'h01 : bcd_inc(mon);
    if (c_mon)  next_o[8*FLD_YEAR +: 8] = (year >= 8'h99) ? 8'h00 : bcd_inc(year);
  end

  assign evt_min  = step & c_sec;
  assign evt_hour = step & c_min;
  assign evt_day  = step & c_hour;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    localparam logic [7:0] RST_VAL = (i == FLD_DAY || i == FLD_MON) ? 8'h01 : 8'h00;
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= RST_VAL;
      else if (wr_en && wr_field == 3'(i)) q <= wdata;
      else if (step)                       q <= next_o[8*i +: 8];
    end
    assign time_o[8*i +: 8] = q;
  end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [2:0]              wr_field,
  input  logic [7:0]              wdata,
  input  logic                    step,
  input  logic [8*NUM_FIELDS-1:0] cand,
  output logic [8*NUM_FIELDS-1:0] alarm_o,
  output logic                    hit
);
  logic [NUM_FIELDS-1:0] eq;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_alm
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= 8'h00;
      else if (wr_en && wr_field == 3'(i)) q <= wdata;
    end
    assign alarm_o[8*i +: 8] = q;
    assign eq[i] = (cand[8*i +: 8] == q);
  end

  // all six fields must agree; there is no field mask
  assign hit = step & (&eq);
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);
  localparam int TW = 8 * NUM_FIELDS;

  logic [2:0]    field;
  logic          word_ok, time_sel, alm_sel;
  logic          time_we, alm_we, ctrl_we, stat_we, ien_we;
  logic          run_q, busy, sec_step;
  logic [TW-1:0] time_v, next_v, alarm_v;
  logic          evt_min, evt_hour, evt_day, alarm_hit, alarm_clr;
  logic [4:0]    flg_q, flg_set, flg_clr;
  logic          ien_alarm_q, ien_timer_q;
  logic          alarm_flag, sec_flag;

  assign field    = addr[4:2];
  assign word_ok  = (addr[1:0] == 2'b00) && (field < 3'(NUM_FIELDS));
  assign time_sel = (addr[7:5] == BANK_TIME)  && word_ok;
  assign alm_sel  = (addr[7:5] == BANK_ALARM) && word_ok;
  assign time_we  = wr_en & time_sel;
  assign alm_we   = wr_en & alm_sel;
  assign ctrl_we  = wr_en & (addr == OFS_CTRL);
  assign stat_we  = wr_en & (addr == OFS_STAT);
  assign ien_we   = wr_en & (addr == OFS_IEN);

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_q),
    .tick_en (tick_en),
    .restart (time_we),
    .busy    (busy),
    .step    (sec_step)
  );

  rtc_calendar u_cal (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (sec_step),
    .wr_en    (time_we),
    .wr_field (field),
    .wdata    (wdata),
    .time_o   (time_v),
    .next_o   (next_v),
    .evt_min  (evt_min),
    .evt_hour (evt_hour),
    .evt_day  (evt_day)
  );

  rtc_alarm u_alm (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (alm_we),
    .wr_field (field),
    .wdata    (wdata),
    .step     (sec_step),
    .cand     (next_v),
    .alarm_o  (alarm_v),
    .hit      (alarm_hit)
  );

  // flag vector maps to status bits 6..2: alarm, day, hour, minute, second
  assign flg_set   = {alarm_hit, evt_day, evt_hour, evt_min, sec_step};
  assign flg_clr   = stat_we ? wdata[6:2] : 5'b0;
  assign alarm_clr = flg_clr[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= 1'b0;
      flg_q       <= '0;
      ien_alarm_q <= 1'b0;
      ien_timer_q <= 1'b0;
    end else begin
      if (ctrl_we) run_q <= wdata[0];
      flg_q <= (flg_q & ~flg_clr) | flg_set;
      if (ien_we) begin
        ien_alarm_q <= wdata[3];
        ien_timer_q <= wdata[2];
      end
    end
  end

  assign alarm_flag = flg_q[4];
  assign sec_flag   = flg_q[0];
  assign irq = (alarm_flag & ien_alarm_q) | (sec_flag & ien_timer_q);

  always_comb begin
    rdata = 8'h00;
    if (time_sel)              rdata = time_v[8*field +: 8];
    else if (alm_sel)          rdata = alarm_v[8*field +: 8];
    else if (addr == OFS_CTRL) rdata = {7'b0, run_q};
    else if (addr == OFS_STAT) rdata = {1'b0, flg_q, run_q, busy};
    else if (addr == OFS_IEN)  rdata = {4'b0, ien_alarm_q, ien_timer_q, 2'b00};
  end
endmodule

// File: rtl/rtc_core_checker.sv
module rtc_core_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        sec_step,
  input logic        busy,
  input logic        run_q,
  input logic        time_we,
  input logic [47:0] time_v,
  input logic        alarm_flag,
  input logic        alarm_clr,
  input logic        sec_flag,
  input logic        irq,
  input logic        ien_alarm_q,
  input logic        ien_timer_q
);
  p_busy_before_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sec_step |-> busy);

  p_stopped_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !time_we) |=> $stable(time_v));

  p_sec_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_step && time_v[7:0] <= 8'h59) |=> time_v[7:0] <= 8'h59);

  p_event_on_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sec_step |=> sec_flag);

  p_alarm_needs_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(sec_step));

  p_alarm_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !alarm_clr) |=> alarm_flag);

  p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_alarm_q && !ien_timer_q) |-> !irq);
endmodule

bind bcd_rtc_core rtc_core_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sec_step    (sec_step),
  .busy        (busy),
  .run_q       (run_q),
  .time_we     (time_we),
  .time_v      (time_v),
  .alarm_flag  (alarm_flag),
  .alarm_clr   (alarm_clr),
  .sec_flag    (sec_flag),
  .irq         (irq),
  .ien_alarm_q (ien_alarm_q),
  .ien_timer_q (ien_timer_q)
);

// File: tb/sim_bcd_rtc_core.sv
`timescale 1ns/1ps
module sim_bcd_rtc_core;
  localparam int TPS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_rtc_core #(.TICKS_PER_SEC(TPS)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic set_time(input logic [7:0] y, mo, d, h, mi, s);
    wr(8'h14, y); wr(8'h10, mo); wr(8'h0C, d);
    wr(8'h08, h); wr(8'h04, mi); wr(8'h00, s);
  endtask

  task automatic set_alarm(input logic [7:0] y, mo, d, h, mi, s);
    wr(8'h34, y); wr(8'h30, mo); wr(8'h2C, d);
    wr(8'h28, h); wr(8'h24, mi); wr(8'h20, s);
  endtask

  task automatic expect_time(input string req, input logic [7:0] y, mo, d, h, mi, s);
    logic [7:0] v;
    rd(8'h00, v); check(req, v, s);
    rd(8'h04, v); check(req, v, mi);
    rd(8'h08, v); check(req, v, h);
    rd(8'h0C, v); check(req, v, d);
    rd(8'h10, v); check(req, v, mo);
    rd(8'h14, v); check(req, v, y);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    expect_time("R1 time", 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    rd(8'h20, v); check("R1 alarm sec", v, 8'h00);
    rd(8'h34, v); check("R1 alarm year", v, 8'h00);
    rd(8'h40, v); check("R1 ctrl", v, 8'h00);
    rd(8'h44, v); check("R1 status", v, 8'h00);
    rd(8'h48, v); check("R1 ien", v, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_regmap;
    logic [7:0] v;
    set_alarm(8'h37, 8'h11, 8'h22, 8'h13, 8'h44, 8'h55);
    rd(8'h34, v); check("R2 alarm year", v, 8'h37);
    rd(8'h2C, v); check("R2 alarm day", v, 8'h22);
    rd(8'h20, v); check("R2 alarm sec", v, 8'h55);
    set_time(8'h42, 8'h07, 8'h19, 8'h08, 8'h33, 8'h12);
    expect_time("R2 time", 8'h42, 8'h07, 8'h19, 8'h08, 8'h33, 8'h12);
  endtask

  task automatic t_stopped;
    logic [7:0] v;
    ticks(3 * TPS);
    rd(8'h00, v); check("R3 stopped sec", v, 8'h12);
    rd(8'h44, v); check("R3 run bit clear", v & 8'h02, 8'h00);
    wr(8'h40, 8'h01);
    rd(8'h44, v); check("R3 run bit set", v & 8'h02, 8'h02);
  endtask

  task automatic t_busy_prescale;
    logic [7:0] v;
    wr(8'h00, 8'h05);
    ticks(TPS - 2);
    rd(8'h44, v); check("R5 busy early", v & 8'h01, 8'h00);
    ticks(1);
    rd(8'h44, v); check("R5 busy set", v & 8'h01, 8'h01);
    rd(8'h00, v); check("R4 sec held", v, 8'h05);
    ticks(1);
    rd(8'h00, v); check("R4 sec step", v, 8'h06);
    rd(8'h44, v); check("R5 busy clear", v & 8'h01, 8'h00);
    ticks(TPS - 1);
    wr(8'h00, 8'h20);
    ticks(TPS - 1);
    rd(8'h00, v); check("R4 restart holds", v, 8'h20);
    ticks(1);
    rd(8'h00, v); check("R4 restart step", v, 8'h21);
  endtask

  task automatic t_bcd_carry;
    logic [7:0] v;
    wr(8'h00, 8'h09);
    ticks(TPS);
    rd(8'h00, v); check("R6 digit carry", v, 8'h10);
    set_time(8'h42, 8'h07, 8'h19, 8'h08, 8'h59, 8'h59);
    ticks(TPS);
    expect_time("R6 hour carry", 8'h42, 8'h07, 8'h19, 8'h09, 8'h00, 8'h00);
  endtask

  task automatic t_rollover;
    logic [7:0] v;
    wr(8'h44, 8'h7C);
    set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    ticks(TPS);
    expect_time("R7 year wrap", 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    rd(8'h44, v); check("R9 all events", v, 8'h3E);
    wr(8'h44, 8'h7C);
    ticks(TPS);
    rd(8'h44, v); check("R9 second only", v, 8'h06);
  endtask

  task automatic t_months;
    set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    ticks(TPS);
    expect_time("R7 leap feb", 8'h24, 8'h02, 8'h29, 8'h00, 8'h00, 8'h00);
    set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    ticks(TPS);
    expect_time("R7 common feb", 8'h23, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00);
    set_time(8'h23, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
    ticks(TPS);
    expect_time("R7 april", 8'h23, 8'h05, 8'h01, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_alarm;
    logic [7:0] v;
    wr(8'h48, 8'h00);
    set_alarm(8'h25, 8'h03, 8'h15, 8'h10, 8'h20, 8'h31);
    set_time(8'h24, 8'h03, 8'h15, 8'h10, 8'h20, 8'h30);
    wr(8'h44, 8'h7C);
    ticks(TPS);
    rd(8'h44, v); check("R8 year differs", v & 8'h40, 8'h00);
    wr(8'h34, 8'h24);
    set_time(8'h24, 8'h03, 8'h15, 8'h10, 8'h20, 8'h30);
    ticks(TPS);
    rd(8'h44, v); check("R8 full match", v & 8'h40, 8'h40);
    check("R11 masked irq", {7'b0, irq}, 8'h00);
    wr(8'h48, 8'h08);
    check("R11 alarm irq", {7'b0, irq}, 8'h01);
    wr(8'h44, 8'h00);
    rd(8'h44, v); check("R10 zero keeps", v & 8'h40, 8'h40);
    wr(8'h44, 8'h40);
    rd(8'h44, v); check("R10 w1c alarm", v & 8'h40, 8'h00);
    check("R10 irq after clear", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_timer_irq;
    logic [7:0] v;
    wr(8'h44, 8'h7C);
    wr(8'h48, 8'h04);
    check("R11 no event no irq", {7'b0, irq}, 8'h00);
    ticks(TPS);
    check("R11 timer irq", {7'b0, irq}, 8'h01);
    wr(8'h48, 8'h00);
    check("R11 ien zero", {7'b0, irq}, 8'h00);
    rd(8'h44, v); check("R9 flag stays", v & 8'h04, 8'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_regmap;
    t_stopped;
    t_busy_prescale;
    t_bcd_carry;
    t_rollover;
    t_months;
    t_alarm;
    t_timer_irq;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule